// File: doc/BRIEF.md
# Handshaked Parallel Register-Bus Slave

This block is the slave end of an asynchronous parallel host bus that reaches a small peripheral register file. The host supplies an 8-bit address, an 8-bit write value, and three active-low controls: select, read strobe and write strobe. The block answers each command with an active-low ready, and keeps ready low for as long as the host holds the strobe. The bidirectional data bus appears as three ports: a data input, a data output and an output enable that belongs to the pad. All controls are resynchronised to the local processor clock before any decision is made on them.

Behind the bus there are four general-purpose read/write registers, a read-to-clear alarm status register and a read-only view of the live alarm inputs. A change on any alarm input sets its status bit and pulls the active-low interrupt. Reading the status register clears only the bits that the read returned. Once no status bit remains set, the interrupt is released. Each select assertion carries at most one command, and select must go high before the next command is taken.

Top module: `pbus_regslave`

## Requirements
- R1: While reset is held and just after it, rdy_n and irq_n are high, dout_oe is low, and the general-purpose registers hold 0x00.
- R2: With cs_n low, a fall of rd_n pulls rdy_n low at the third rising clock edge after the fall. At that point dout_oe is high and dout carries the addressed register. A strobe given while cs_n is high draws no ready and no data.
- R3: dout_oe is high only while rdy_n is low during a read; otherwise dout is 0x00.
- R4: When the strobe returns high, rdy_n returns high and dout_oe returns low at the third rising edge after the strobe rise.
- R5: With cs_n low, a fall of wr_n writes din into the register at addr 0x00..0x03. rdy_n then stays low until wr_n returns high.
- R6: After one command, any further strobe within the same cs_n low period is ignored: rdy_n stays high and no register changes.
- R7: Reads of addresses other than 0x00..0x03, 0x10 and 0x11 return 0x00. Writes to any address other than 0x00..0x03 change nothing.
- R8: A change in either direction on alarm bit i sets status bit i (address 0x10). irq_n is low one clock edge after the change.
- R9: A read of 0x10 returns the status bits and clears, at the end of that read, only the bits it returned. Changes that arrive during the read stay set. irq_n goes high once no status bit remains set.
- R10: Address 0x11 reads the present alarm input levels and cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock used as the timing reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 8 | Register address |
| din | input | 8 | Data bus value driven by the host |
| dout | output | 8 | Read data toward the data bus pads |
| dout_oe | output | 1 | Enables the data bus output drivers |
| rdy_n | output | 1 | Active-low ready, cycle complete |
| irq_n | output | 1 | Active-low alarm interrupt |
| alarm | input | 8 | Alarm levels, synchronous to clk |

## Verification
The assertions assume that the host keeps addr and din steady from the select fall until the strobe rises. They also assume that the host never asserts both strobes in one command and that the alarm inputs are already synchronous to clk. The bench drives every pin on the falling clock edge. It sets up select and address before the strobe, holds them until ready has risen and select has gone high, and changes alarm levels only on falling edges. Every bus cycle, including the mid-read alarm change, therefore stays inside those assumptions.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_HOLD  = 2'd3
  } bus_state_t;

  // synchronised active-low level went from high to low
  function automatic logic went_low(input logic cur, input logic prev);
    return !cur && prev;
  endfunction

  // address falls inside the general-purpose register window
  function automatic logic in_gp_window(input logic [7:0] a, input int unsigned n);
    return ({24'd0, a} < n);
  endfunction

  // status update: drop reported bits, then add fresh changes (set wins)
  function automatic logic [7:0] status_next(input logic [7:0] stat,
                                             input logic [7:0] drop,
                                             input logic [7:0] fresh);
    return (stat & ~drop) | fresh;
  endfunction

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int          W    = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= INIT;
      stage2 <= INIT;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          rd_s,
  input  logic          wr_s,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] rdata,
  output logic          rd_start,
  output logic          wr_start,
  output logic          rd_end,
  output bus_state_t    state,
  output logic [DW-1:0] dout_q,
  output logic [AW-1:0] lat_addr
);
  logic       rd_prev;
  logic       wr_prev;
  logic       rd_fall;
  logic       wr_fall;
  logic       wr_end;
  bus_state_t state_nx;

  assign rd_fall  = went_low(rd_s, rd_prev);
  assign wr_fall  = went_low(wr_s, wr_prev);
  assign rd_start = (state == ST_IDLE) && !cs_s && rd_fall;
  assign wr_start = (state == ST_IDLE) && !cs_s && wr_fall && !rd_start;
  assign rd_end   = (state == ST_READ) && rd_s;
  assign wr_end   = (state == ST_WRITE) && wr_s;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (rd_start) state_nx = ST_READ;
                else if (wr_start) state_nx = ST_WRITE;
      ST_READ:  if (rd_end) state_nx = ST_HOLD;
      ST_WRITE: if (wr_end) state_nx = ST_HOLD;
      ST_HOLD:  if (cs_s) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rd_prev  <= 1'b1;
      wr_prev  <= 1'b1;
      dout_q   <= '0;
      lat_addr <= '0;
    end else begin
      state   <= state_nx;
      rd_prev <= rd_s;
      wr_prev <= wr_s;
      if (rd_start) begin
        dout_q   <= rdata;
        lat_addr <= addr;
      end
    end
  end
endmodule

// File: rtl/pbus_regs.sv
module pbus_regs
  import pbus_pkg::*;
#(
  parameter int          AW        = 8,
  parameter int          DW        = 8,
  parameter int          NUM_REGS  = 4,
  parameter logic [AW-1:0] STAT_ADDR = 8'h10,
  parameter logic [AW-1:0] LIVE_ADDR = 8'h11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] alarm,
  input  logic          clr_en,
  input  logic [DW-1:0] clr_mask,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] stat,
  output logic [DW-1:0] chg
);
  logic [DW-1:0] gp [NUM_REGS];
  logic [DW-1:0] alarm_prev;
  logic [DW-1:0] drop;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_gp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gp[gi] <= '0;
      else if (wr_en && addr == AW'(gi)) gp[gi] <= din;
    end
  end

  assign chg  = alarm ^ alarm_prev;
  assign drop = clr_en ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_prev <= '0;
      stat       <= '0;
    end else begin
      alarm_prev <= alarm;
      stat       <= status_next(stat, drop, chg);
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == STAT_ADDR) rdata = stat;
    else if (addr == LIVE_ADDR) rdata = alarm;
    else if (in_gp_window(addr, NUM_REGS)) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (addr == AW'(i)) rdata = gp[i];
    end
  end
endmodule

// File: rtl/pbus_regslave.sv
module pbus_regslave
  import pbus_pkg::*;
#(
  parameter int          AW        = 8,
  parameter int          DW        = 8,
  parameter int          NUM_REGS  = 4,
  parameter logic [AW-1:0] STAT_ADDR = 8'h10,
  parameter logic [AW-1:0] LIVE_ADDR = 8'h11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          rdy_n,
  output logic          irq_n,
  input  logic [DW-1:0] alarm
);
  logic [2:0]    ctl_s;
  logic          cs_s;
  logic          rd_s;
  logic          wr_s;
  logic          rd_start;
  logic          wr_start;
  logic          rd_end;
  bus_state_t    state;
  logic [DW-1:0] dout_q;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] rdata;
  logic [DW-1:0] stat;
  logic [DW-1:0] alarm_chg;
  logic          stat_clr;

  pbus_sync #(.W(3), .INIT(3'b111)) i_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, rd_n, wr_n}), .q(ctl_s)
  );
  assign {cs_s, rd_s, wr_s} = ctl_s;

  pbus_ctrl #(.AW(AW), .DW(DW)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .rd_s(rd_s), .wr_s(wr_s),
    .addr(addr), .rdata(rdata), .rd_start(rd_start), .wr_start(wr_start),
    .rd_end(rd_end), .state(state), .dout_q(dout_q), .lat_addr(lat_addr)
  );

  assign stat_clr = rd_end && (lat_addr == STAT_ADDR);

  pbus_regs #(.AW(AW), .DW(DW), .NUM_REGS(NUM_REGS),
              .STAT_ADDR(STAT_ADDR), .LIVE_ADDR(LIVE_ADDR)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_start), .addr(addr), .din(din),
    .alarm(alarm), .clr_en(stat_clr), .clr_mask(dout_q),
    .rdata(rdata), .stat(stat), .chg(alarm_chg)
  );

  assign dout_oe = (state == ST_READ);
  assign dout    = dout_oe ? dout_q : '0;
  assign rdy_n   = !((state == ST_READ) || (state == ST_WRITE));
  assign irq_n   = ~|stat;
endmodule

// File: rtl/pbus_regslave_chk.sv
module pbus_regslave_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_start,
  input logic          wr_start,
  input logic          stat_clr,
  input logic [DW-1:0] alarm_chg,
  input logic          rdy_n,
  input logic          dout_oe,
  input logic          irq_n
);
  // R3: the data drivers are on only inside an acknowledged read
  a_r3_oe_inside_ready: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> !rdy_n);

  // R4: ready and the data drivers are released on the same edge
  a_r4_release_together: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_n) |-> !dout_oe);

  // R2, R5: an accepted command is acknowledged on the next edge
  a_r5_start_acks: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start || wr_start) |=> !rdy_n);

  // R6: after a cycle ends, ready stays high for at least one more edge
  a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_n) |=> rdy_n);

  // R8: the interrupt only falls after an alarm change
  a_r8_irq_from_change: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(|alarm_chg));

  // R9: the interrupt is only released by a status read
  a_r9_irq_release_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(stat_clr));
endmodule

bind pbus_regslave pbus_regslave_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .wr_start(wr_start),
  .stat_clr(stat_clr), .alarm_chg(alarm_chg), .rdy_n(rdy_n),
  .dout_oe(dout_oe), .irq_n(irq_n)
);

// File: tb/test_pbus_regslave.sv
module test_pbus_regslave;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic [7:0] addr = 8'h00;
  logic [7:0] din = 8'h00;
  logic [7:0] alarm = 8'h00;
  logic [7:0] dout;
  logic       dout_oe;
  logic       rdy_n;
  logic       irq_n;

  int checks = 0;
  int errors = 0;

  pbus_regslave i_pbus_regslave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .rdy_n(rdy_n), .irq_n(irq_n), .alarm(alarm)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // read cycle; returns data seen while ready is low and both latencies
  task automatic bus_read(input logic [7:0] a, output logic [7:0] data,
                          output int lat_on, output int lat_off);
    int n;
    @(negedge clk); cs_n = 1'b0; addr = a;
    @(negedge clk); rd_n = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (rdy_n && n < 10);
    lat_on = n;
    data = dout;
    check(dout_oe == 1'b1, "R3 oe during read", int'(dout_oe), 1);
    rd_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!rdy_n && n < 10);
    lat_off = n;
    check(dout_oe == 1'b0 && dout == 8'h00, "R3 bus released", int'(dout), 0);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    int n;
    @(negedge clk); cs_n = 1'b0; addr = a; din = d;
    @(negedge clk); wr_n = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (rdy_n && n < 10);
    check(n == 3, "R5 write ready latency", n, 3);
    repeat (3) @(negedge clk);
    check(rdy_n == 1'b0, "R5 ready held while strobe low", int'(rdy_n), 0);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rdy_n == 1'b1, "R4 ready released after write", int'(rdy_n), 1);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_read(input logic [7:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    int lon, loff;
    bus_read(a, d, lon, loff);
    check(d == exp, req, int'(d), int'(exp));
  endtask

  task automatic t_reset();
    check(rdy_n && irq_n && !dout_oe, "R1 outputs during reset",
          {rdy_n, irq_n, dout_oe}, 3'b110);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rdy_n && irq_n && !dout_oe, "R1 outputs after reset",
          {rdy_n, irq_n, dout_oe}, 3'b110);
    expect_read(8'h02, 8'h00, "R1 register cleared");
  endtask

  task automatic t_read_timing();
    logic [7:0] d;
    int lon, loff;
    bus_write(8'h01, 8'hA5);
    bus_read(8'h01, d, lon, loff);
    check(d == 8'hA5, "R2 read data", int'(d), 8'hA5);
    check(lon == 3, "R2 ready latency", lon, 3);
    check(loff == 3, "R4 release latency", loff, 3);
  endtask

  task automatic t_patterns();
    bus_write(8'h00, 8'h3C);
    bus_write(8'h03, 8'hFF);
    bus_write(8'h02, 8'h81);
    expect_read(8'h00, 8'h3C, "R5 reg0 pattern");
    expect_read(8'h03, 8'hFF, "R5 reg3 pattern");
    expect_read(8'h02, 8'h81, "R5 reg2 pattern");
  endtask

  task automatic t_no_select();
    @(negedge clk); addr = 8'h00; rd_n = 1'b0;
    repeat (8) @(negedge clk);
    check(rdy_n == 1'b1 && dout_oe == 1'b0, "R2 strobe without select",
          {rdy_n, dout_oe}, 2'b10);
    rd_n = 1'b1;
    @(negedge clk); din = 8'h11; wr_n = 1'b0;
    repeat (8) @(negedge clk);
    check(rdy_n == 1'b1, "R2 write strobe without select", int'(rdy_n), 1);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_read(8'h00, 8'h3C, "R2 no write without select");
  endtask

  task automatic t_second_strobe();
    int n;
    @(negedge clk); cs_n = 1'b0; addr = 8'h01; din = 8'h5A;
    @(negedge clk); wr_n = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (rdy_n && n < 10);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    din = 8'hC3; wr_n = 1'b0;
    repeat (8) @(negedge clk);
    check(rdy_n == 1'b1, "R6 second write strobe ignored", int'(rdy_n), 1);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    rd_n = 1'b0;
    repeat (8) @(negedge clk);
    check(rdy_n == 1'b1 && dout_oe == 1'b0, "R6 second read strobe ignored",
          {rdy_n, dout_oe}, 2'b10);
    rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_read(8'h01, 8'h5A, "R6 only first write kept");
  endtask

  task automatic t_unmapped();
    bus_write(8'h05, 8'h77);
    expect_read(8'h05, 8'h00, "R7 unmapped write and read");
    expect_read(8'h40, 8'h00, "R7 unmapped read");
    bus_write(8'h10, 8'hFF);
    expect_read(8'h10, 8'h00, "R7 status not writable");
    check(irq_n == 1'b1, "R7 status write raises nothing", int'(irq_n), 1);
    bus_write(8'h11, 8'hFF);
    expect_read(8'h11, 8'h00, "R10 live register not writable");
  endtask

  task automatic t_alarm();
    logic [7:0] d;
    int n;
    @(negedge clk); alarm = 8'h01;
    @(negedge clk);
    check(irq_n == 1'b0, "R8 irq one edge after change", int'(irq_n), 0);
    // read status; change bit1 while the read is acknowledged
    @(negedge clk); cs_n = 1'b0; addr = 8'h10;
    @(negedge clk); rd_n = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (rdy_n && n < 10);
    d = dout;
    check(d == 8'h01, "R9 status read value", int'(d), 1);
    alarm = 8'h03;
    @(negedge clk); rd_n = 1'b1;
    repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (4) @(negedge clk);
    check(irq_n == 1'b0, "R9 irq kept for change during read", int'(irq_n), 0);
    expect_read(8'h11, 8'h03, "R10 live alarm levels");
    expect_read(8'h10, 8'h02, "R9 only reported bits cleared");
    check(irq_n == 1'b1, "R9 irq released when clear", int'(irq_n), 1);
    @(negedge clk); alarm = 8'h00;
    @(negedge clk);
    check(irq_n == 1'b0, "R8 falling alarm also sets status", int'(irq_n), 0);
    expect_read(8'h10, 8'h03, "R8 both falling bits set");
    check(irq_n == 1'b1, "R9 irq released again", int'(irq_n), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_read_timing();
    t_patterns();
    t_no_select();
    t_second_strobe();
    t_unmapped();
    t_alarm();
    finish_run();
  end
endmodule